// File: doc/BRIEF.md
# Multichannel PWM Run and Interrupt Control Registers

This block is the shared control register bank of a multichannel pulse-width modulator. A simple memory-mapped bus with single-cycle accesses reaches it. It holds one run flag, one interrupt-mask flag and one pending-event flag for each channel. The channel count can be set up to 32; the default build has four. The run flags go out to the channel counters. Each counter returns a one-cycle pulse when its period completes. A single interrupt line goes to the processor.

Run and mask flags never need a read-modify-write. One word address turns bits on and a second turns them off, and zero bits in either write change nothing. Pending flags are acknowledged by reading them: a read of the pending word returns every flag and clears them in the same access. The block also keeps a general mode word for the clock generator. It decodes the per-channel register windows, which start at byte address 0x200 with a 0x20 stride, into a one-hot select so that the channel blocks can pick up their own accesses.

Top module: `pwmg_ctrl`

## Requirements
- R1: After a synchronous reset all run, mask and pending flags are 0, `mode_cfg` is 0, `irq` is low and `bus_rdata` is 0.
- R2: A write to byte address 0x04 sets each run flag whose `bus_wdata` bit is 1 and leaves the flags written with 0 unchanged. Run flags change only through 0x04 and 0x08.
- R3: A write to byte address 0x08 clears each run flag whose `bus_wdata` bit is 1 and leaves the others unchanged.
- R4: A read of 0x0C returns the run flags in bits NCH-1:0 and zero in the bits above.
- R5: Writes to 0x10 set mask flags and writes to 0x14 clear them, both bit by bit with 1 meaning act. A read of 0x18 returns the mask.
- R6: A pulse on `evt_period[n]` sets pending flag n at the next clock edge, whatever the state of the run and mask flags.
- R7: A read of 0x1C returns the pending flags and clears every flag it returned.
- R8: A pulse on `evt_period[n]` in the same cycle as a read of 0x1C leaves flag n pending after that read.
- R9: `irq` is high exactly when some channel has both its pending flag and its mask flag set.
- R10: Byte address 0x00 is a full 32-bit read/write word whose value drives `mode_cfg`.
- R11: While `bus_rd` or `bus_wr` is high and `bus_addr` lies in the window 0x200+0x20*n with n<NCH, `chan_hit` is one-hot at bit n. Otherwise `chan_hit` is 0. `chan_word` is always `bus_addr[4:2]`. Reads inside a window return 0 from this block.
- R12: Read data is registered. It appears after the clock edge that samples `bus_rd` and holds until the next read. Writes to 0x0C, 0x18 and 0x1C have no effect. Any access with `bus_addr[1:0]` not 0 is ignored and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (11) | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_period | input | NCH (4) | One-cycle period-end pulses, one per channel |
| ch_run | output | NCH (4) | Run flag per channel |
| irq | output | 1 | Combined masked interrupt |
| mode_cfg | output | 32 | Mode word for the clock generator |
| chan_hit | output | NCH (4) | One-hot select for the per-channel register windows |
| chan_word | output | 3 | Word offset inside a channel window |

## Verification
The bench sweeps all sixteen patterns of the four-channel build through set, clear and read-back of the run and mask words. A design that mixed up set and clear, or that let zero bits clear flags, would then report a status that differs from the arithmetic model. It crosses every pending pattern with every mask pattern on `irq`, which exposes a missing AND or an unmasked OR. It sends a period pulse in the same cycle as a pending read, where a design that gives the acknowledge priority would drop an event for good. It also probes the first address past the last channel window and the read-only and misaligned addresses. A decoder that compares too few address bits would assert a select or corrupt state there.

// File: rtl/pwmg_pkg.sv
package pwmg_pkg;

    localparam int DW = 32;

    // Word index inside the global block (byte address bits 4:2)
    typedef enum logic [2:0] {
        GW_MODE  = 3'd0,
        GW_RSET  = 3'd1,
        GW_RCLR  = 3'd2,
        GW_RSTAT = 3'd3,
        GW_MSET  = 3'd4,
        GW_MCLR  = 3'd5,
        GW_MASK  = 3'd6,
        GW_PEND  = 3'd7
    } gword_e;

    // Channel windows: base 0x200, stride 0x20, so block index = addr >> 5
    localparam int WIN_SHIFT     = 5;
    localparam int WIN_FIRST_BLK = 'h200 >> WIN_SHIFT;

    typedef enum logic [2:0] {
        RS_ZERO,
        RS_MODE,
        RS_RUN,
        RS_MASK,
        RS_PEND
    } rsel_e;

    typedef struct packed {
        logic mode_wr;
        logic run_set;
        logic run_clr;
        logic msk_set;
        logic msk_clr;
        logic pend_ack;
    } ctl_s;

    localparam ctl_s CTL_IDLE = '{default: 1'b0};

    // Zero-extend a channel vector to a bus word
    function automatic logic [DW-1:0] widen(input logic [DW-1:0] v, input int n);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) begin
            r[i] = (i < n) ? v[i] : 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/pwmg_decode.sv
module pwmg_decode
    import pwmg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 11
) (
    input  logic [AW-1:0]  addr,
    input  logic           wr,
    input  logic           rd,
    output ctl_s           ctl,
    output rsel_e          rsel,
    output logic           rd_en,
    output logic [NCH-1:0] chan_hit,
    output logic [2:0]     chan_word
);
    localparam int BW = AW - WIN_SHIFT;

    logic [BW-1:0] blk;
    logic          aligned;
    logic          global_hit;
    gword_e        gw;

    assign blk        = addr[AW-1:WIN_SHIFT];
    assign aligned    = (addr[1:0] == 2'b00);
    assign global_hit = aligned && (blk == '0);
    assign gw         = gword_e'(addr[4:2]);
    assign chan_word  = addr[4:2];
    assign rd_en      = rd;

    always_comb begin
        ctl = CTL_IDLE;
        if (wr && global_hit) begin
            unique case (gw)
                GW_MODE: ctl.mode_wr = 1'b1;
                GW_RSET: ctl.run_set = 1'b1;
                GW_RCLR: ctl.run_clr = 1'b1;
                GW_MSET: ctl.msk_set = 1'b1;
                GW_MCLR: ctl.msk_clr = 1'b1;
                default: ;
            endcase
        end
        if (rd && global_hit && gw == GW_PEND) begin
            ctl.pend_ack = 1'b1;
        end
    end

    always_comb begin
        rsel = RS_ZERO;
        if (global_hit) begin
            unique case (gw)
                GW_MODE:  rsel = RS_MODE;
                GW_RSTAT: rsel = RS_RUN;
                GW_MASK:  rsel = RS_MASK;
                GW_PEND:  rsel = RS_PEND;
                default:  rsel = RS_ZERO;
            endcase
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_win
        assign chan_hit[i] = (rd || wr) && aligned
                             && (blk == BW'(WIN_FIRST_BLK + i));
    end

endmodule

// File: rtl/pwmg_chan_bit.sv
module pwmg_chan_bit
    import pwmg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ctl_s ctl,
    input  logic wbit,
    input  logic evt,
    output logic run,
    output logic msk,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
        end else if (ctl.run_set && wbit) begin
            run <= 1'b1;
        end else if (ctl.run_clr && wbit) begin
            run <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msk <= 1'b0;
        end else if (ctl.msk_set && wbit) begin
            msk <= 1'b1;
        end else if (ctl.msk_clr && wbit) begin
            msk <= 1'b0;
        end
    end

    // A new event wins over the acknowledge so it is never lost
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
        end else if (evt) begin
            pend <= 1'b1;
        end else if (ctl.pend_ack) begin
            pend <= 1'b0;
        end
    end

endmodule

// File: rtl/pwmg_rdmux.sv
module pwmg_rdmux
    import pwmg_pkg::*;
#(
    parameter int NCH = 4
) (
    input  rsel_e          rsel,
    input  logic [DW-1:0]  mode,
    input  logic [NCH-1:0] run,
    input  logic [NCH-1:0] msk,
    input  logic [NCH-1:0] pend,
    output logic [DW-1:0]  word
);
    always_comb begin
        unique case (rsel)
            RS_MODE: word = mode;
            RS_RUN:  word = widen(DW'(run), NCH);
            RS_MASK: word = widen(DW'(msk), NCH);
            RS_PEND: word = widen(DW'(pend), NCH);
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/pwmg_ctrl.sv
module pwmg_ctrl
    import pwmg_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NCH-1:0]   evt_period,
    output logic [NCH-1:0]   ch_run,
    output logic             irq,
    output logic [DW-1:0]    mode_cfg,
    output logic [NCH-1:0]   chan_hit,
    output logic [2:0]       chan_word
);
    ctl_s           ctl;
    rsel_e          rsel;
    logic           rd_en;
    logic [NCH-1:0] run_v;
    logic [NCH-1:0] msk_v;
    logic [NCH-1:0] pend_v;
    logic [DW-1:0]  rd_word;
    logic [DW-1:0]  mode_q;

    pwmg_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .ctl       (ctl),
        .rsel      (rsel),
        .rd_en     (rd_en),
        .chan_hit  (chan_hit),
        .chan_word (chan_word)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        pwmg_chan_bit u_bit (
            .clk  (clk),
            .rst  (rst),
            .ctl  (ctl),
            .wbit (bus_wdata[i]),
            .evt  (evt_period[i]),
            .run  (run_v[i]),
            .msk  (msk_v[i]),
            .pend (pend_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (ctl.mode_wr) begin
            mode_q <= bus_wdata;
        end
    end

    pwmg_rdmux #(.NCH(NCH)) u_mux (
        .rsel (rsel),
        .mode (mode_q),
        .run  (run_v),
        .msk  (msk_v),
        .pend (pend_v),
        .word (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_word;
        end
    end

    assign ch_run   = run_v;
    assign mode_cfg = mode_q;
    assign irq      = |(pend_v & msk_v);

endmodule

// File: rtl/pwmg_ctrl_chk.sv
module pwmg_ctrl_chk #(
    parameter int NCH = 4,
    parameter int AW  = 11
) (
    input logic           clk,
    input logic           rst,
    input logic [AW-1:0]  bus_addr,
    input logic           bus_wr,
    input logic           bus_rd,
    input logic [31:0]    bus_wdata,
    input logic [NCH-1:0] evt_period,
    input logic [NCH-1:0] run,
    input logic [NCH-1:0] msk,
    input logic [NCH-1:0] pend,
    input logic           irq,
    input logic [NCH-1:0] chan_hit
);
    localparam logic [AW-1:0] A_RSET = AW'(32'h04);
    localparam logic [AW-1:0] A_RCLR = AW'(32'h08);
    localparam logic [AW-1:0] A_MSET = AW'(32'h10);
    localparam logic [AW-1:0] A_PEND = AW'(32'h1C);

    logic [NCH-1:0] wbits;
    assign wbits = bus_wdata[NCH-1:0];

    assert_run_set_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_RSET) |=> ((run & $past(wbits)) == $past(wbits)));

    assert_run_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && (bus_addr == A_RSET || bus_addr == A_RCLR)) |=> $stable(run));

    assert_run_clr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_RCLR) |=> ((run & $past(wbits)) == '0));

    assert_mask_set_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_MSET) |=> ((msk & $past(wbits)) == $past(wbits)));

    assert_evt_pend_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_period != '0) |=> ((pend & $past(evt_period)) == $past(evt_period)));

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_PEND && evt_period == '0) |=> (pend == '0));

    assert_irq_needs_mask_R9: assert property (@(posedge clk) disable iff (rst)
        (msk == '0) |-> !irq);

    assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> !irq);

    assert_hit_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_hit));

endmodule

bind pwmg_ctrl pwmg_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .evt_period (evt_period),
    .run        (run_v),
    .msk        (msk_v),
    .pend       (pend_v),
    .irq        (irq),
    .chan_hit   (chan_hit)
);

// File: tb/sim_pwmg_ctrl.sv
module sim_pwmg_ctrl;
    localparam int T   = 10;
    localparam int NCH = 4;
    localparam int AW  = 11;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] evt_period = '0;
    logic [NCH-1:0] ch_run;
    logic           irq;
    logic [31:0]    mode_cfg;
    logic [NCH-1:0] chan_hit;
    logic [2:0]     chan_word;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(T/2) clk = ~clk;

    pwmg_ctrl #(.NCH(NCH), .AW(AW)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [NCH-1:0] p);
        @(negedge clk);
        evt_period = p;
        @(negedge clk);
        evt_period = '0;
    endtask

    initial begin
        logic [31:0]    d;
        logic [NCH-1:0] run_m;
        logic [NCH-1:0] msk_m;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 run", 32'(ch_run), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 mode", mode_cfg, 0);
        check("R1 rdata", bus_rdata, 0);
        rd('h18, d); check("R1 mask", d, 0);
        rd('h1C, d); check("R1 pend", d, 0);

        // R2/R3/R4: sweep set and clear patterns on the run flags
        run_m = '0;
        for (int s = 0; s < 16; s++) begin
            wr('h04, 32'(s) | 32'hFFFF_FFF0 & 32'h0);
            run_m |= NCH'(s);
            check("R2 run set", 32'(ch_run), 32'(run_m));
            rd('h0C, d); check("R4 status", d, 32'(run_m));
            for (int c = 0; c < 16; c += 5) begin
                wr('h08, 32'(c));
                run_m &= ~NCH'(c);
                check("R3 run clr", 32'(ch_run), 32'(run_m));
            end
        end
        wr('h04, 32'hFFFF_FFFF); run_m = '1;
        rd('h0C, d); check("R4 upper zero", d, 32'hF);
        wr('h08, 32'hF); run_m = '0;
        check("R3 all clr", 32'(ch_run), 0);

        // R5: mask set/clear sweep
        msk_m = '0;
        for (int s = 0; s < 16; s++) begin
            wr('h10, 32'(s)); msk_m |= NCH'(s);
            rd('h18, d); check("R5 mask set", d, 32'(msk_m));
            wr('h14, 32'(15 - s)); msk_m &= ~NCH'(15 - s);
            rd('h18, d); check("R5 mask clr", d, 32'(msk_m));
        end

        // R6/R7/R9: every pending pattern against every mask pattern
        for (int p = 0; p < 16; p++) begin
            pulse(NCH'(p));
            for (int m = 0; m < 16; m++) begin
                wr('h10, 32'(m));
                wr('h14, 32'(~m & 15));
                check("R9 irq", 32'(irq), 32'((p & m) != 0));
            end
            rd('h1C, d); check("R6/R7 pend read", d, 32'(p));
            rd('h1C, d); check("R7 cleared", d, 0);
            check("R9 irq after ack", 32'(irq), 0);
        end
        // R6: pending sets while the channel is stopped and masked out
        wr('h14, 32'hF);
        pulse(4'b1000);
        rd('h1C, d); check("R6 stopped masked", d, 32'h8);

        // R8: event in the same cycle as the acknowledge read
        pulse(4'b0101);
        @(negedge clk);
        bus_addr = AW'('h1C); bus_rd = 1'b1; evt_period = 4'b0010;
        @(negedge clk);
        bus_rd = 1'b0; evt_period = '0;
        check("R8 read value", bus_rdata, 32'h5);
        rd('h1C, d); check("R8 kept pending", d, 32'h2);
        rd('h1C, d); check("R8 then clear", d, 0);

        // R10: mode word
        wr('h00, 32'hA5C3_1E96);
        check("R10 mode out", mode_cfg, 32'hA5C3_1E96);
        rd('h00, d); check("R10 mode read", d, 32'hA5C3_1E96);

        // R12: read-only and misaligned addresses, and held read data
        wr('h0C, 32'hF); check("R12 status write ignored", 32'(ch_run), 0);
        wr('h18, 32'hF); rd('h18, d); check("R12 mask write ignored", d, 0);
        wr('h05, 32'hF); check("R12 misaligned ignored", 32'(ch_run), 0);
        wr('h01, 32'h0); check("R12 misaligned mode", mode_cfg, 32'hA5C3_1E96);
        rd('h02, d); check("R12 misaligned read", d, 0);
        rd('h00, d);
        repeat (3) @(negedge clk);
        check("R12 rdata holds", bus_rdata, 32'hA5C3_1E96);

        // R11: channel window decode
        for (int n = 0; n <= NCH; n++) begin
            for (int w = 0; w < 8; w += 3) begin
                @(negedge clk);
                bus_addr = AW'('h200 + 'h20 * n + 4 * w); bus_rd = 1'b1;
                #1;
                check("R11 hit", 32'(chan_hit), (n < NCH) ? 32'(1 << n) : 0);
                check("R11 word", 32'(chan_word), 32'(w));
                @(negedge clk);
                bus_rd = 1'b0;
                check("R11 window reads zero", bus_rdata, 0);
            end
        end
        @(negedge clk);
        bus_addr = AW'('h200); #1;
        check("R11 idle no hit", 32'(chan_hit), 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule